// File: doc/BRIEF.md
# Dual-Clock FIFO with Mailbox Bypass

This block moves 36-bit words in one direction, from a producer port on one clock to a consumer port on a second clock. The two clocks run freely and may be unrelated or the same net. Storage holds 64 words. Each side sees its own occupancy flags, computed in its own clock domain. The producer sees full and almost-full. The consumer sees empty and almost-empty. Word pointers cross between the domains as Gray code through two-stage synchronisers.

Two single-word mailbox registers sit beside the queue, one for each direction. A port raises its mailbox-select input to reach its mailbox instead of the queue. A mailbox write sets a new-mail flag at the other port, and a read by that port clears it. While the flag is set, the mailbox refuses further writes, so the word waiting in it cannot be lost.

The almost-flag distance is chosen at reset by a two-bit select. It is the same on both sides.

Top module: `dcfifo_mbox`

## Requirements
- R1: While rst_n is low and after it rises, b_empty and b_aempty are 1, a_full, a_afull, a_mail_new and b_mail_new are 0, and a_dout and b_dout are 0. A reset also empties a queue that held data.
- R2: An access happens on a rising edge only when cs_n is 0 and en is 1. On port A, a_wr=1 with a_mbox=0 enqueues a_din. On port B, b_wr=0 with b_mbox=0 dequeues, and the word appears on b_dout after that edge. Words leave in the order they entered.
- R3: Each flag asserts right after the edge of its own port's access. A flag that depends on the other port's pointer clears only after two further edges of its own clock. With a shared clock, b_empty falls two edges after the write, and a_full falls two edges after the read.
- R4: fs_sel is captured during reset and sets the offset: 0 gives 16, 1 gives 12, 2 gives 8, 3 gives 4. b_aempty is 1 when stored words are at or below the offset. a_afull is 1 when free words are at or below the offset.
- R5: a_full is 1 with 64 words stored, and a write attempted then changes nothing.
- R6: A dequeue attempted while b_empty is 1 leaves b_dout and the pointers unchanged.
- R7: A port A write with a_mbox=1 loads the A-to-B mailbox and sets b_mail_new. A port B read with b_mbox=1 returns that word on b_dout and clears b_mail_new. The B-to-A mailbox works the same way with the ports swapped: b_wr=1 and b_mbox=1 write it, a_wr=0 and a_mbox=1 read it onto a_dout, and a_mail_new is the flag.
- R8: While a mailbox's new-mail flag is set, or until the clear has crossed back to the writer, a write to that mailbox is ignored. Once the clear has crossed back, a new write is accepted.
- R9: Mailbox accesses do not change the queue pointers or the queue flags.
- R10: With cs_n at 1, or en at 0, a port does nothing, whatever its other inputs are.
- R11: With a shared clock, an enqueue and a dequeue on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Producer-side clock |
| clk_b | input | 1 | Consumer-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_sel | input | 2 | Almost-flag offset select, captured in reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_mbox | input | 1 | Port A selects its mailbox |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A mailbox read data |
| a_full | output | 1 | Queue full, clk_a domain |
| a_afull | output | 1 | Queue almost full, clk_a domain |
| a_mail_new | output | 1 | B-to-A mailbox holds unread mail |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_mbox | input | 1 | Port B selects its mailbox |
| b_din | input | 36 | Port B mailbox write data |
| b_dout | output | 36 | Port B read data (queue or mailbox) |
| b_empty | output | 1 | Queue empty, clk_b domain |
| b_aempty | output | 1 | Queue almost empty, clk_b domain |
| b_mail_new | output | 1 | A-to-B mailbox holds unread mail |

## Verification
The queue is driven with interleaved writes and reads taken from a vector table, which checks ordering at several fill levels. A same-edge write and read shows that both pointers move together. A fill to capacity and a drain to empty, at offset selects 3 and 0, find the exact word counts where each almost flag switches. The same run shows that extra writes and reads at the limits change nothing. Flag timing is sampled edge by edge after a single write and a single read, which separates the immediate local update from the two-edge crossing delay. Mailbox traffic, a refused second write and accesses with select or enable inactive are each followed by queue-flag and data checks, which shows that none of them leaks into the queue.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef struct packed {
    logic fifo;
    logic mbox_wr;
    logic mbox_rd;
  } port_acc_t;

  function automatic port_acc_t port_decode(input logic cs_n, input logic en,
                                            input logic is_write, input logic mbox,
                                            input logic fifo_dir);
    port_acc_t r;
    logic      live;
    live      = !cs_n && en;
    r.fifo    = live && !mbox && (is_write == fifo_dir);
    r.mbox_wr = live && mbox && is_write;
    r.mbox_rd = live && mbox && !is_write;
    return r;
  endfunction

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [4:0] sel_offset(input logic [1:0] s);
    return 5'd16 - {1'b0, s, 2'b00};
  endfunction

endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int W     = 36,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fs_sel,
  input  logic          wr_req,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-2:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          wr_fire,
  output logic          full,
  output logic          afull
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_s, used, room, off_q;

  // offset captured while the domain is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= PW'(sel_offset(fs_sel));
  end

  always_comb begin
    rbin_s  = PW'(gray2bin(32'(rgray_s)));
    used    = wbin_q - rbin_s;
    room    = PW'(DEPTH) - used;
    full    = (used == PW'(DEPTH));
    afull   = (room <= off_q);
    wr_fire = wr_req && !full;
    wbin_d  = wbin_q + PW'(1);
    wgray_d = PW'(bin2gray(32'(wbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[PW-2:0];
  assign wgray = wgray_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH)); // R5
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req) |=> $stable(wbin_q)); // R5
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q))); // R3
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fs_sel,
  input  logic          rd_req,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-2:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          rd_fire,
  output logic          empty,
  output logic          aempty
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wbin_s, used, off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= PW'(sel_offset(fs_sel));
  end

  always_comb begin
    wbin_s  = PW'(gray2bin(32'(wgray_s)));
    used    = wbin_s - rbin_q;
    empty   = (used == '0);
    aempty  = (used <= off_q);
    rd_fire = rd_req && !empty;
    rbin_d  = rbin_q + PW'(1);
    rgray_d = PW'(bin2gray(32'(rbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_fire) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign raddr = rbin_q[PW-2:0];
  assign rgray = rgray_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH)); // R6
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req) |=> $stable(rbin_q)); // R6
  AST_AEMPTY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty); // R4
endmodule

// File: rtl/dcfifo_mail.sv
module dcfifo_mail #(
  parameter int W = 36
) (
  input  logic         clk_w,
  input  logic         rst_w_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clk_r,
  input  logic         rst_r_n,
  input  logic         rd_en,
  output logic [W-1:0] mail_q,
  output logic         new_flag
);
  logic         wtog_q, wtog_d, ack_s;
  logic         ack_q, ack_d, wtog_s;
  logic         busy, wr_fire, rd_take;
  logic [W-1:0] data_q;

  dcfifo_sync #(.W(1)) u_ack_xing (
    .clk(clk_w), .rst_n(rst_w_n), .d(ack_q), .q(ack_s));
  dcfifo_sync #(.W(1)) u_tog_xing (
    .clk(clk_r), .rst_n(rst_r_n), .d(wtog_q), .q(wtog_s));

  // writer domain
  always_comb begin
    busy    = (wtog_q != ack_s);
    wr_fire = wr_en && !busy;
    wtog_d  = wr_fire ? !wtog_q : wtog_q;
  end

  always_ff @(posedge clk_w or negedge rst_w_n) begin
    if (!rst_w_n) begin
      wtog_q <= 1'b0;
      data_q <= '0;
    end else begin
      wtog_q <= wtog_d;
      if (wr_fire) data_q <= wr_data;
    end
  end

  // reader domain
  always_comb begin
    new_flag = (wtog_s != ack_q);
    rd_take  = rd_en && new_flag;
    ack_d    = rd_take ? !ack_q : ack_q;
  end

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n) ack_q <= 1'b0;
    else          ack_q <= ack_d;
  end

  assign mail_q = data_q;

  AST_MBOX_LOCKED: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (busy && wr_en) |=> $stable(data_q)); // R8
  AST_MBOX_CLEAR: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (new_flag && rd_en) |=> !new_flag); // R7
endmodule

// File: rtl/dcfifo_mbox.sv
module dcfifo_mbox
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic [1:0]        fs_sel,
  input  logic              a_cs_n,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_full,
  output logic              a_afull,
  output logic              a_mail_new,
  input  logic              b_cs_n,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic              b_mbox,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_empty,
  output logic              b_aempty,
  output logic              b_mail_new
);
  port_acc_t         acc_a, acc_b;
  logic              rst_a_n, rst_b_n;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] ram_q, mail1_q, mail2_q;
  logic [DATA_W-1:0] a_dout_q, a_dout_d, b_dout_q, b_dout_d;

  assign acc_a = port_decode(a_cs_n, a_en, a_wr, a_mbox, 1'b1);
  assign acc_b = port_decode(b_cs_n, b_en, b_wr, b_mbox, 1'b0);

  dcfifo_rst_sync u_rst_a (.clk(clk_a), .arst_n(rst_n), .srst_n(rst_a_n));
  dcfifo_rst_sync u_rst_b (.clk(clk_b), .arst_n(rst_n), .srst_n(rst_b_n));

  dcfifo_sync #(.W(PW)) u_rptr_xing (
    .clk(clk_a), .rst_n(rst_a_n), .d(rgray), .q(rgray_s));
  dcfifo_sync #(.W(PW)) u_wptr_xing (
    .clk(clk_b), .rst_n(rst_b_n), .d(wgray), .q(wgray_s));

  dcfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(clk_a), .rst_n(rst_a_n), .fs_sel(fs_sel), .wr_req(acc_a.fifo),
    .rgray_s(rgray_s), .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire),
    .full(a_full), .afull(a_afull));

  dcfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(clk_b), .rst_n(rst_b_n), .fs_sel(fs_sel), .rd_req(acc_b.fifo),
    .wgray_s(wgray_s), .raddr(raddr), .rgray(rgray), .rd_fire(rd_fire),
    .empty(b_empty), .aempty(b_aempty));

  dcfifo_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk_a), .we(wr_fire), .waddr(waddr), .wdata(a_din),
    .raddr(raddr), .rdata(ram_q));

  dcfifo_mail #(.W(DATA_W)) u_mail_ab (
    .clk_w(clk_a), .rst_w_n(rst_a_n), .wr_en(acc_a.mbox_wr), .wr_data(a_din),
    .clk_r(clk_b), .rst_r_n(rst_b_n), .rd_en(acc_b.mbox_rd),
    .mail_q(mail1_q), .new_flag(b_mail_new));

  dcfifo_mail #(.W(DATA_W)) u_mail_ba (
    .clk_w(clk_b), .rst_w_n(rst_b_n), .wr_en(acc_b.mbox_wr), .wr_data(b_din),
    .clk_r(clk_a), .rst_r_n(rst_a_n), .rd_en(acc_a.mbox_rd),
    .mail_q(mail2_q), .new_flag(a_mail_new));

  always_comb begin
    a_dout_d = a_dout_q;
    if (acc_a.mbox_rd) a_dout_d = mail2_q;
  end

  always_comb begin
    b_dout_d = b_dout_q;
    if (rd_fire)            b_dout_d = ram_q;
    else if (acc_b.mbox_rd) b_dout_d = mail1_q;
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) a_dout_q <= '0;
    else          a_dout_q <= a_dout_d;
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) b_dout_q <= '0;
    else          b_dout_q <= b_dout_d;
  end

  assign a_dout = a_dout_q;
  assign b_dout = b_dout_q;

  AST_RESET_EMPTY: assert property (@(posedge clk_b)
    !rst_b_n |-> (b_empty && b_aempty)); // R1
  AST_MBOX_NO_FIFO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_mbox && !a_cs_n && a_en) |=> $stable(wgray)); // R9
  AST_IDLE_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_cs_n || !b_en) |=> ($stable(rgray) && $stable(b_dout))); // R10
endmodule

// File: tb/sim_dcfifo_mbox.sv
module sim_dcfifo_mbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fs_sel;
  logic        a_cs_n, a_en, a_wr, a_mbox;
  logic [35:0] a_din, a_dout;
  logic        a_full, a_afull, a_mail_new;
  logic        b_cs_n, b_en, b_wr, b_mbox;
  logic [35:0] b_din, b_dout;
  logic        b_empty, b_aempty, b_mail_new;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dcfifo_mbox u0 (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n), .fs_sel(fs_sel),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbox(a_mbox), .a_din(a_din),
    .a_dout(a_dout), .a_full(a_full), .a_afull(a_afull), .a_mail_new(a_mail_new),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbox(b_mbox), .b_din(b_din),
    .b_dout(b_dout), .b_empty(b_empty), .b_aempty(b_aempty), .b_mail_new(b_mail_new));

  // {is_write, data, expected read data}
  localparam logic [72:0] TBL [8] = '{
    {1'b1, 36'h1_1111_0001, 36'h0},
    {1'b1, 36'h2_2222_0002, 36'h0},
    {1'b0, 36'h0,           36'h1_1111_0001},
    {1'b1, 36'h3_3333_0003, 36'h0},
    {1'b0, 36'h0,           36'h2_2222_0002},
    {1'b0, 36'h0,           36'h3_3333_0003},
    {1'b1, 36'hF_0F0F_0004, 36'h0},
    {1'b0, 36'h0,           36'hF_0F0F_0004}
  };

  function automatic logic [35:0] pat(input int i);
    return 36'hA_0000_0000 + 36'(i) * 36'h0_0101_0003;
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0; a_mbox = 1'b0;
    b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b0; b_mbox = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] fs);
    idle_all();
    rst_n = 1'b0; fs_sel = fs;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic a_op(input logic wr, input logic mb, input logic [35:0] d);
    a_cs_n = 1'b0; a_en = 1'b1; a_wr = wr; a_mbox = mb; a_din = d;
    tick(1);
    a_cs_n = 1'b1; a_en = 1'b0;
  endtask

  task automatic b_op(input logic wr, input logic mb, input logic [35:0] d);
    b_cs_n = 1'b0; b_en = 1'b1; b_wr = wr; b_mbox = mb; b_din = d;
    tick(1);
    b_cs_n = 1'b1; b_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a_din = '0; b_din = '0;
    rst_n = 1'b0; fs_sel = 2'd3;
    idle_all();
    tick(2);
    check("R1 empty in reset", 36'(b_empty), 36'd1);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1 empty",     36'(b_empty),    36'd1);
    check("R1 aempty",    36'(b_aempty),   36'd1);
    check("R1 full",      36'(a_full),     36'd0);
    check("R1 afull",     36'(a_afull),    36'd0);
    check("R1 mail flags", 36'({a_mail_new, b_mail_new}), 36'd0);
    check("R1 b_dout",    b_dout, 36'd0);
    check("R1 a_dout",    a_dout, 36'd0);

    // R3 empty clears two edges after the write
    a_op(1'b1, 1'b0, 36'h5_5555_5555);
    check("R3 empty after write edge", 36'(b_empty), 36'd1);
    tick(1);
    check("R3 empty one edge later", 36'(b_empty), 36'd1);
    tick(1);
    check("R3 empty two edges later", 36'(b_empty), 36'd0);
    b_op(1'b0, 1'b0, '0);
    check("R2 first word", b_dout, 36'h5_5555_5555);
    check("R3 empty asserts at once", 36'(b_empty), 36'd1);

    // R2 table walk
    for (int i = 0; i < 8; i++) begin
      if (TBL[i][72]) a_op(1'b1, 1'b0, TBL[i][71:36]);
      else begin
        b_op(1'b0, 1'b0, '0);
        check("R2 order", b_dout, TBL[i][35:0]);
      end
      tick(3);
    end

    // R10 inactive ports
    a_cs_n = 1'b1; a_en = 1'b1; a_wr = 1'b1; a_mbox = 1'b0; a_din = 36'hB_AD00_0001;
    tick(1);
    a_cs_n = 1'b0; a_en = 1'b0;
    tick(1);
    a_cs_n = 1'b1;
    tick(3);
    check("R10 A idle no write", 36'(b_empty), 36'd1);
    a_op(1'b1, 1'b0, 36'h7_0000_0010);
    tick(3);
    b_cs_n = 1'b1; b_en = 1'b1; b_wr = 1'b0; b_mbox = 1'b0;
    tick(1);
    b_cs_n = 1'b0; b_en = 1'b0;
    tick(1);
    b_cs_n = 1'b1;
    check("R10 B idle dout", b_dout, 36'hF_0F0F_0004);
    check("R10 B idle keeps word", 36'(b_empty), 36'd0);
    b_op(1'b0, 1'b0, '0);
    check("R10 word still queued", b_dout, 36'h7_0000_0010);

    // R11 same-edge write and read
    a_op(1'b1, 1'b0, 36'h8_0000_00A1);
    tick(3);
    a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_mbox = 1'b0; a_din = 36'h8_0000_00A2;
    b_cs_n = 1'b0; b_en = 1'b1; b_wr = 1'b0; b_mbox = 1'b0;
    tick(1);
    idle_all();
    check("R11 read on shared edge", b_dout, 36'h8_0000_00A1);
    tick(3);
    b_op(1'b0, 1'b0, '0);
    check("R11 write on shared edge", b_dout, 36'h8_0000_00A2);
    check("R11 empty after", 36'(b_empty), 36'd1);

    // R7 R8 R9 mailboxes
    a_op(1'b1, 1'b1, 36'hC_AFE0_0001);
    tick(2);
    check("R7 b_mail_new set", 36'(b_mail_new), 36'd1);
    a_op(1'b1, 1'b1, 36'hD_EAD0_0002);
    tick(1);
    check("R9 mailbox write keeps empty", 36'(b_empty), 36'd1);
    b_op(1'b0, 1'b1, '0);
    check("R7 mail A to B data", b_dout, 36'hC_AFE0_0001);
    check("R8 blocked write lost", b_dout, 36'hC_AFE0_0001);
    check("R7 b_mail_new cleared", 36'(b_mail_new), 36'd0);
    check("R9 mailbox read keeps empty", 36'(b_empty), 36'd1);
    tick(4);
    a_op(1'b1, 1'b1, 36'hC_AFE0_0003);
    tick(2);
    b_op(1'b0, 1'b1, '0);
    check("R8 write accepted after clear", b_dout, 36'hC_AFE0_0003);
    check("R7 no stray a_mail_new", 36'(a_mail_new), 36'd0);
    b_op(1'b1, 1'b1, 36'h6_1234_5678);
    tick(2);
    check("R7 a_mail_new set", 36'(a_mail_new), 36'd1);
    a_op(1'b0, 1'b1, '0);
    check("R7 mail B to A data", a_dout, 36'h6_1234_5678);
    check("R7 a_mail_new cleared", 36'(a_mail_new), 36'd0);
    tick(3);
    check("R9 queue still empty", 36'(b_empty), 36'd1);

    // R4 R5 R6 fill and drain with offset 4 (fs_sel=3)
    for (int i = 0; i < 64; i++) begin
      a_op(1'b1, 1'b0, pat(i));
      if (i == 3) begin
        tick(3);
        check("R4 aempty at 4 words", 36'(b_aempty), 36'd1);
      end
      if (i == 4) begin
        tick(3);
        check("R4 aempty at 5 words", 36'(b_aempty), 36'd0);
      end
      if (i == 58) check("R4 afull at 59 words", 36'(a_afull), 36'd0);
      if (i == 59) check("R4 afull at 60 words", 36'(a_afull), 36'd1);
    end
    check("R5 full at 64", 36'(a_full), 36'd1);
    a_op(1'b1, 1'b0, 36'hE_EEEE_EEEE);
    check("R5 still full", 36'(a_full), 36'd1);
    tick(3);
    b_op(1'b0, 1'b0, '0);
    check("R5 first after fill", b_dout, pat(0));
    check("R3 full held after read", 36'(a_full), 36'd1);
    tick(1);
    check("R3 full one edge later", 36'(a_full), 36'd1);
    tick(1);
    check("R3 full clears two edges later", 36'(a_full), 36'd0);
    for (int i = 1; i < 64; i++) begin
      b_op(1'b0, 1'b0, '0);
      check("R5 drain order", b_dout, pat(i));
    end
    check("R5 extra write dropped", 36'(b_empty), 36'd1);
    b_op(1'b0, 1'b0, '0);
    check("R6 read on empty holds dout", b_dout, pat(63));
    tick(4);
    check("R6 still empty", 36'(b_empty), 36'd1);

    // R1 reset empties queue, R4 offset 16 (fs_sel=0)
    a_op(1'b1, 1'b0, pat(1));
    a_op(1'b1, 1'b0, pat(2));
    tick(3);
    do_reset(2'd0);
    check("R1 reset empties queue", 36'(b_empty), 36'd1);
    check("R1 reset b_dout", b_dout, 36'd0);
    for (int i = 0; i < 17; i++) begin
      a_op(1'b1, 1'b0, pat(i));
      if (i == 15) begin
        tick(3);
        check("R4 aempty at 16 words", 36'(b_aempty), 36'd1);
      end
    end
    tick(3);
    check("R4 aempty at 17 words", 36'(b_aempty), 36'd0);

    finish_run();
  end
endmodule